// File: doc/BRIEF.md
# ADC Conversion Request Sequencer

This block is the digital control for a multi-channel successive-approximation converter. It watches register-style inputs (a two-bit mode field, a channel number, a start bit, and an injection-request bit with its own channel) and issues one-cycle start pulses to the converter core. Each pulse carries the channel to convert. A flag says whether the running conversion is injected. Done strobes are kept apart for standard and injected conversions, and a busy flag covers the whole job.

The analog core is replaced by an internal timer. It reports completion a fixed, parameterised number of cycles after each start pulse, so the sequencer can be used and checked on its own. The mode field selects one of four modes:

| Value | Mode |
|-------|------|
| 00 | one fixed-channel conversion |
| 01 | repeated fixed-channel conversions |
| 10 | one downward scan |
| 11 | repeated downward scans |

Requests are taken only on rising edges. Mode and channel changes are applied at conversion or sequence boundaries. Standard and injected requests follow fixed wait-or-abort rules.

Top module: `adcq_seq`

## Requirements
- R1: While reset is held, busy_o, conv_start_o, conv_done_o, inj_done_o and conv_is_inj_o are 0 and conv_chan_o is 0.
- R2: A conversion's done strobe appears exactly LAT cycles after its one-cycle start pulse. busy_o is 1 up to and including the done cycle of the last conversion of the job, and 0 the cycle after when nothing else waits.
- R3: With mode 00, a rising start bit produces exactly one start pulse, in the cycle after the edge is sampled, carrying the channel on chan_i.
- R4: Only a 0-to-1 change of start_i or inj_req_i is a request. A start bit held at 1 after its job ends starts nothing more.
- R5: With mode 10, a rising start from channel n converts n, n-1, ..., 0 and then stops. Each next start pulse comes the cycle after the previous done strobe.
- R6: A change of chan_i during a scan has no effect on the scan in progress.
- R7: With mode 11, the scan repeats from chan_i while start_i is 1 at the end of channel 0. Clearing start_i mid-scan lets the scan finish at channel 0 and then stops.
- R8: With mode 01, the conversion repeats while start_i is 1. chan_i is sampled afresh at each conversion end, and clearing start_i stops after the current conversion.
- R9: The mode field is applied when a conversion ends. Switching to 10 or 11 while a fixed conversion of channel n runs continues with n-1 down to 0.
- R10: With no conversion running or waiting, changing the mode (including to 10 or 11) while start_i stays 0 starts nothing.
- R11: A rising start during a running standard conversion aborts it and starts the new request on chan_i the next cycle. The aborted conversion never strobes done.
- R12: An injected request during a standard conversion starts the cycle after that conversion's done strobe. A standard request during an injected conversion likewise waits for the injected done strobe.
- R13: An injected request during an injected conversion is held (one deep) and starts, with inj_chan_i sampled then, the cycle after the running one finishes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Conversion mode: 00 fixed once, 01 fixed repeated, 10 scan once, 11 scan repeated |
| chan_i | input | CH_W | Standard channel number |
| start_i | input | 1 | Standard start bit (rising edge requests) |
| inj_req_i | input | 1 | Injection request bit (rising edge requests) |
| inj_chan_i | input | CH_W | Channel for injected conversions |
| conv_start_o | output | 1 | One-cycle start pulse to the converter core |
| conv_chan_o | output | CH_W | Channel of the current conversion |
| conv_is_inj_o | output | 1 | Current conversion is an injected one |
| busy_o | output | 1 | A conversion is running or waiting |
| conv_done_o | output | 1 | Standard conversion done strobe |
| inj_done_o | output | 1 | Injected conversion done strobe |

## Verification
The assertions assume that inputs change only between clock edges and that start_i and inj_req_i are 0 when reset is released, so that no edge is seen on the first cycle. The scan-step property also assumes that mode_i is steady across a done cycle. The bench drives every input half a cycle away from the rising edge and returns both request bits to 0 between scenarios. Mode changes are placed well inside a conversion, never on a done cycle.

// File: rtl/adcq_pkg.sv
package adcq_pkg;

   typedef enum logic [1:0] {
      RUN_NONE = 2'd0,
      RUN_STD  = 2'd1,
      RUN_INJ  = 2'd2
   } run_t;

   // mode bit 1 selects scanning, bit 0 selects repetition
   function automatic logic mode_scans(input logic [1:0] m);
      return m[1];
   endfunction

   function automatic logic mode_repeats(input logic [1:0] m);
      return m[0];
   endfunction

endpackage

// File: rtl/adcq_edge.sv
module adcq_edge #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lvl_i,
   output logic [N-1:0] rise_o
);

   if (N < 1) begin : g_bad_n
      $error("adcq_edge: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      logic prev_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prev_q <= 1'b0;
         else        prev_q <= lvl_i[i];
      end

      assign rise_o[i] = lvl_i[i] & ~prev_q;

      // a level must fall before it can request again
      assert_single_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
         rise_o[i] |=> !rise_o[i]);
   end

endmodule

// File: rtl/adcq_timer.sv
module adcq_timer #(
   parameter int LAT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go_i,
   output logic fin_o
);

   localparam int CW = $clog2(LAT + 1);

   if (LAT < 2) begin : g_bad_lat
      $error("adcq_timer: LAT must be at least 2");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (go_i)           cnt_q <= CW'(LAT);
      else if (cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
   end

   // a restart in flight hides the end of the conversion it replaces
   assign fin_o = (cnt_q == CW'(1)) && !go_i;

   assert_no_early_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
      go_i |=> !fin_o);

endmodule

// File: rtl/adcq_next.sv
module adcq_next #(
   parameter int CW = 3
) (
   input  logic [1:0]    mode_i,
   input  logic [CW-1:0] cur_ch_i,
   input  logic [CW-1:0] chan_i,
   input  logic          start_lvl_i,
   output logic          more_o,
   output logic [CW-1:0] nxt_ch_o
);
   import adcq_pkg::*;

   always_comb begin
      more_o   = 1'b0;
      nxt_ch_o = chan_i;
      if (mode_scans(mode_i) && cur_ch_i != '0) begin
         more_o   = 1'b1;
         nxt_ch_o = cur_ch_i - CW'(1);
      end else if (mode_repeats(mode_i) && start_lvl_i) begin
         more_o   = 1'b1;
         nxt_ch_o = chan_i;
      end
   end

endmodule

// File: rtl/adcq_seq.sv
module adcq_seq #(
   parameter int CH_W = 3,
   parameter int LAT  = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [1:0]      mode_i,
   input  logic [CH_W-1:0] chan_i,
   input  logic            start_i,
   input  logic            inj_req_i,
   input  logic [CH_W-1:0] inj_chan_i,
   output logic            conv_start_o,
   output logic [CH_W-1:0] conv_chan_o,
   output logic            conv_is_inj_o,
   output logic            busy_o,
   output logic            conv_done_o,
   output logic            inj_done_o
);
   import adcq_pkg::*;

   if (CH_W < 1) begin : g_bad_w
      $error("adcq_seq: CH_W must be at least 1");
   end

   logic [1:0]      rise;
   logic            std_rise, inj_rise, fin;
   logic            more;
   logic [CH_W-1:0] cont_ch;

   run_t            run_q;
   logic            seq_live_q, inj_pend_q, start_q, inj_q;
   logic [CH_W-1:0] nxt_q, chan_q;

   logic            free, std_end, std_job, inj_job;
   logic [CH_W-1:0] std_ch;

   adcq_edge #(.N(2)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl_i ({inj_req_i, start_i}),
      .rise_o(rise)
   );
   assign std_rise = rise[0];
   assign inj_rise = rise[1];

   adcq_timer #(.LAT(LAT)) u_timer (
      .clk  (clk),
      .rst_n(rst_n),
      .go_i (start_q),
      .fin_o(fin)
   );

   adcq_next #(.CW(CH_W)) u_next (
      .mode_i     (mode_i),
      .cur_ch_i   (chan_q),
      .chan_i     (chan_i),
      .start_lvl_i(start_i),
      .more_o     (more),
      .nxt_ch_o   (cont_ch)
   );

   always_comb begin
      free    = (run_q == RUN_NONE) || fin;
      std_end = fin && (run_q == RUN_STD);
      inj_job = inj_pend_q || inj_rise;
      std_job = std_rise || (std_end ? more : seq_live_q);
      std_ch  = std_rise ? chan_i : (std_end ? cont_ch : nxt_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q      <= RUN_NONE;
         seq_live_q <= 1'b0;
         inj_pend_q <= 1'b0;
         start_q    <= 1'b0;
         inj_q      <= 1'b0;
         nxt_q      <= '0;
         chan_q     <= '0;
      end else begin
         start_q <= 1'b0;
         if (free && inj_job) begin
            run_q      <= RUN_INJ;
            start_q    <= 1'b1;
            inj_q      <= 1'b1;
            chan_q     <= inj_chan_i;
            inj_pend_q <= 1'b0;
            seq_live_q <= std_job;
            nxt_q      <= std_ch;
         end else if (std_rise && (free || run_q == RUN_STD)) begin
            run_q      <= RUN_STD;
            start_q    <= 1'b1;
            inj_q      <= 1'b0;
            chan_q     <= chan_i;
            seq_live_q <= 1'b0;
            inj_pend_q <= inj_job;
         end else if (free && std_job) begin
            run_q      <= RUN_STD;
            start_q    <= 1'b1;
            inj_q      <= 1'b0;
            chan_q     <= std_ch;
            seq_live_q <= 1'b0;
            inj_pend_q <= inj_job;
         end else begin
            if (fin) run_q <= RUN_NONE;
            seq_live_q <= std_job;
            nxt_q      <= std_ch;
            inj_pend_q <= inj_job;
         end
      end
   end

   assign conv_start_o  = start_q;
   assign conv_chan_o   = chan_q;
   assign conv_is_inj_o = inj_q;
   assign conv_done_o   = fin && (run_q == RUN_STD);
   assign inj_done_o    = fin && (run_q == RUN_INJ);
   assign busy_o        = (run_q != RUN_NONE) || seq_live_q || inj_pend_q;

   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !std_rise && !inj_rise) |=> !conv_start_o);

   assert_inj_waits_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q == RUN_STD && !fin) |=> !(conv_start_o && conv_is_inj_o));

   assert_inj_not_preempted_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q == RUN_INJ && !fin) |=> !conv_start_o);

   assert_abort_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q == RUN_STD && std_rise && !fin)
      |=> (conv_start_o && !conv_is_inj_o && conv_chan_o == $past(chan_i)));

   assert_scan_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_done_o && mode_i[1] && conv_chan_o != '0 && !std_rise && !inj_job)
      |=> (conv_start_o && conv_chan_o == $past(conv_chan_o) - CH_W'(1)));

endmodule

// File: tb/adcq_seq_tb.sv
`timescale 1ns/1ps
module adcq_seq_tb;

   localparam int CH_W = 3;
   localparam int LAT  = 4;
   localparam int PER  = LAT + 1;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [1:0]      mode_i = 2'b00;
   logic [CH_W-1:0] chan_i = '0;
   logic            start_i = 1'b0;
   logic            inj_req_i = 1'b0;
   logic [CH_W-1:0] inj_chan_i = '0;
   logic            conv_start_o, conv_is_inj_o, busy_o, conv_done_o, inj_done_o;
   logic [CH_W-1:0] conv_chan_o;

   always #2 clk = ~clk;

   adcq_seq #(.CH_W(CH_W), .LAT(LAT)) u_dut (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .chan_i(chan_i),
      .start_i(start_i), .inj_req_i(inj_req_i), .inj_chan_i(inj_chan_i),
      .conv_start_o(conv_start_o), .conv_chan_o(conv_chan_o),
      .conv_is_inj_o(conv_is_inj_o), .busy_o(busy_o),
      .conv_done_o(conv_done_o), .inj_done_o(inj_done_o)
   );

   int cyc = 0;
   int nchk = 0;
   int nfail = 0;
   int nst = 0;
   int ndn = 0;
   int st_cyc [64];
   int st_ch  [64];
   int st_inj [64];
   int dn_cyc [64];
   int dn_inj [64];

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (rst_n) begin
         if (conv_start_o && nst < 64) begin
            st_cyc[nst] = cyc;
            st_ch[nst]  = int'(conv_chan_o);
            st_inj[nst] = int'(conv_is_inj_o);
            nst++;
         end
         if ((conv_done_o || inj_done_o) && ndn < 64) begin
            dn_cyc[ndn] = cyc;
            dn_inj[ndn] = int'(inj_done_o);
            ndn++;
         end
      end
   end

   task automatic step();
      @(negedge clk);
      #1;
   endtask

   task automatic go_to(input int c);
      while (cyc < c) step();
   endtask

   task automatic clear_log();
      nst = 0;
      ndn = 0;
   endtask

   task automatic chk(input string req, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   initial begin
      #(4 * 150000);
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      int p;
      repeat (3) step();
      // R1 reset state
      chk("R1 busy", int'(busy_o), 0);
      chk("R1 start", int'(conv_start_o), 0);
      chk("R1 done", int'(conv_done_o) + int'(inj_done_o), 0);
      chk("R1 chan", int'(conv_chan_o), 0);
      chk("R1 inj", int'(conv_is_inj_o), 0);
      rst_n = 1'b1;
      step();

      // R2 R3 R4: one fixed conversion per channel, start held high afterwards
      for (int ch = 0; ch < (1 << CH_W); ch++) begin
         clear_log();
         mode_i = 2'b00; chan_i = CH_W'(ch); start_i = 1'b1;
         p = cyc;
         go_to(p + LAT);
         chk("R2 busy during conversion", int'(busy_o), 1);
         go_to(p + LAT + 1);
         chk("R2 done strobe", int'(conv_done_o), 1);
         step();
         chk("R2 busy after done", int'(busy_o), 0);
         go_to(p + 30);
         chk("R4 held start no retrigger", nst, 1);
         chk("R3 channel", st_ch[0], ch);
         chk("R3 start cycle", st_cyc[0], p + 1);
         chk("R2 done cycle", dn_cyc[0], p + 1 + LAT);
         start_i = 1'b0;
         step();
      end

      // R5 R6: single scans from every channel, chan_i disturbed mid-scan
      for (int ch = 0; ch < (1 << CH_W); ch++) begin
         clear_log();
         mode_i = 2'b10; chan_i = CH_W'(ch); start_i = 1'b1;
         p = cyc;
         go_to(p + 2);
         chan_i = CH_W'((1 << CH_W) - 1 - ch);
         go_to(p + PER * (ch + 1) + 15);
         chk("R5 scan length", nst, ch + 1);
         for (int k = 0; k <= ch; k++) begin
            chk("R6 scan channel", st_ch[k], ch - k);
            chk("R5 scan timing", st_cyc[k], p + 1 + PER * k);
         end
         start_i = 1'b0;
         step();
      end

      // R7 repeated scan, start cleared mid-scan
      clear_log();
      mode_i = 2'b11; chan_i = 3'd2; start_i = 1'b1;
      p = cyc;
      go_to(p + 22);
      start_i = 1'b0;
      go_to(p + 60);
      chk("R7 conversions", nst, 6);
      for (int k = 0; k < 6; k++) begin
         chk("R7 channel", st_ch[k], 2 - (k % 3));
         chk("R7 timing", st_cyc[k], p + 1 + PER * k);
      end
      chk("R7 idle after stop", int'(busy_o), 0);
      step();

      // R8 repeated fixed conversion, channel sampled at boundary
      clear_log();
      mode_i = 2'b01; chan_i = 3'd4; start_i = 1'b1;
      p = cyc;
      go_to(p + 2);
      chan_i = 3'd6;
      go_to(p + 8);
      start_i = 1'b0;
      go_to(p + 40);
      chk("R8 conversions", nst, 2);
      chk("R8 first channel", st_ch[0], 4);
      chk("R8 resampled channel", st_ch[1], 6);
      chk("R8 restart cycle", st_cyc[1], p + 1 + PER);
      step();

      // R9 fixed to scan switch while channel 3 converts
      clear_log();
      mode_i = 2'b00; chan_i = 3'd3; start_i = 1'b1;
      p = cyc;
      go_to(p + 2);
      mode_i = 2'b10;
      go_to(p + 40);
      chk("R9 conversions", nst, 4);
      for (int k = 0; k < 4; k++) begin
         chk("R9 channel", st_ch[k], 3 - k);
         chk("R9 timing", st_cyc[k], p + 1 + PER * k);
      end
      start_i = 1'b0;
      step();

      // R10 mode change while idle with start low
      clear_log();
      mode_i = 2'b00; chan_i = 3'd3; start_i = 1'b1;
      p = cyc;
      go_to(p + 8);
      start_i = 1'b0;
      step();
      mode_i = 2'b10;
      go_to(p + 20);
      mode_i = 2'b11;
      go_to(p + 50);
      chk("R10 no extra conversion", nst, 1);
      chk("R10 idle", int'(busy_o), 0);
      mode_i = 2'b00;
      step();

      // R11 abort of a running standard conversion
      clear_log();
      mode_i = 2'b00; chan_i = 3'd5; start_i = 1'b1;
      p = cyc;
      go_to(p + 1);
      start_i = 1'b0;
      go_to(p + 2);
      chan_i = 3'd2; start_i = 1'b1;
      go_to(p + 30);
      chk("R11 starts", nst, 2);
      chk("R11 restart cycle", st_cyc[1], p + 3);
      chk("R11 restart channel", st_ch[1], 2);
      chk("R11 single done", ndn, 1);
      chk("R11 done cycle", dn_cyc[0], p + 3 + LAT);
      start_i = 1'b0;
      step();

      // R12 injected request waits for standard conversion
      clear_log();
      mode_i = 2'b00; chan_i = 3'd5; start_i = 1'b1;
      p = cyc;
      go_to(p + 2);
      inj_chan_i = 3'd6; inj_req_i = 1'b1;
      go_to(p + 30);
      chk("R12 starts", nst, 2);
      chk("R12 injected start cycle", st_cyc[1], p + 1 + PER);
      chk("R12 injected channel", st_ch[1], 6);
      chk("R12 injected flag", st_inj[1], 1);
      chk("R12 injected done cycle", dn_cyc[1], p + 1 + PER + LAT);
      chk("R12 injected done kind", dn_inj[1], 1);
      start_i = 1'b0; inj_req_i = 1'b0;
      step();

      // R12 standard request waits for injected conversion
      clear_log();
      inj_chan_i = 3'd1; inj_req_i = 1'b1;
      p = cyc;
      go_to(p + 2);
      mode_i = 2'b00; chan_i = 3'd4; start_i = 1'b1;
      go_to(p + 30);
      chk("R12 std waits starts", nst, 2);
      chk("R12 std start cycle", st_cyc[1], p + 1 + PER);
      chk("R12 std channel", st_ch[1], 4);
      chk("R12 std flag", st_inj[1], 0);
      chk("R12 std done kind", dn_inj[1], 0);
      start_i = 1'b0; inj_req_i = 1'b0;
      step();

      // R13 injected request queued behind an injected conversion
      clear_log();
      inj_chan_i = 3'd2; inj_req_i = 1'b1;
      p = cyc;
      go_to(p + 1);
      inj_req_i = 1'b0;
      go_to(p + 2);
      inj_chan_i = 3'd3; inj_req_i = 1'b1;
      go_to(p + 30);
      chk("R13 starts", nst, 2);
      chk("R13 queued start cycle", st_cyc[1], p + 1 + PER);
      chk("R13 queued channel", st_ch[1], 3);
      chk("R13 queued flag", st_inj[1], 1);
      chk("R13 dones", ndn, 2);
      inj_req_i = 1'b0;
      step();

      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

endmodule